// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Output-Bus Control

This block is the serial test port of a memory-style device. Four test pins (test clock, mode select, serial in, serial out) step a sixteen-state controller. The controller chooses between a three-bit instruction register and one of three data registers: a one-bit skip register, a fixed 32-bit identification code, and a boundary register with a parameterized number of cells. The boundary register captures a snapshot of the device pins. Values shifted into it can be latched into parallel preload cells.

One preload cell, chosen by a parameter, acts as the enable for the functional output bus while the external-test instruction is current. A separate instruction holds that bus in high impedance whatever the functional enable asks for. With any other instruction the functional enable passes straight through. The serial output changes only on the falling test-clock edge and is enabled only while a register is being shifted.

Top module: `tap_boundary_ctrl`

## Requirements
- R1: At power-up (por_n low) the controller is in Test-Logic-Reset. From any state, five consecutive rising edges of tck with tms high bring it to Test-Logic-Reset.
- R2: tdo and tdo_oe change only on the falling edge of tck. tdo_oe is 1 only while the controller is in Shift-IR or Shift-DR, and it is 0 after power-up.
- R3: The active instruction is 3 bits. It is set to IDCODE (001) at power-up and in Test-Logic-Reset. A newly shifted opcode takes effect only on the Update-IR edge.
- R4: Capture-IR loads 3'b001 into the instruction shift stage, so the first three tdo bits of an instruction shift are 1, 0, 0.
- R5: In every shift, tdi enters the most significant bit of the selected register and tdo presents its least significant bit, so the captured value leaves LSB first.
- R6: BYPASS (111) selects a one-bit register that captures 0 in Capture-DR, so tdi reappears on tdo one shift later.
- R7: IDCODE (001) selects a 32-bit register that captures the parameter ID_VALUE, whose bit 0 must be 1.
- R8: EXTEST (000), SAMPLE/PRELOAD (100) and SAMPLE Z (010) select the boundary register, which captures pin_in in Capture-DR. Under EXTEST and SAMPLE/PRELOAD, Update-DR copies the shift stage into bsr_par. Under SAMPLE Z, Update-DR leaves bsr_par unchanged.
- R9: bus_oe equals bsr_par[OE_CELL] under EXTEST, is 0 under SAMPLE Z, and equals func_oe under any other instruction.
- R10: test_mode is 1 exactly while EXTEST is the active instruction.
- R11: bsr_par is cleared at power-up and whenever the controller is in Test-Logic-Reset.
- R12: The reserved codes 011, 101 and 110 behave as BYPASS. They leave bsr_par unchanged, keep test_mode at 0, and keep bus_oe equal to func_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Test mode select, sampled on rising tck |
| tdi | input | 1 | Serial test data in, sampled on rising tck |
| tdo | output | 1 | Serial test data out, updated on falling tck |
| tdo_oe | output | 1 | Drive enable for tdo (0 means high impedance) |
| pin_in | input | BSR_LEN | Pin values captured by the boundary register |
| func_oe | input | 1 | Output-bus enable requested by the functional logic |
| bsr_par | output | BSR_LEN | Parallel preload cells of the boundary register |
| test_mode | output | 1 | High while EXTEST selects preload values for the pins |
| bus_oe | output | 1 | Final enable of the functional output bus |

## Verification
Each captured value appears on tdo at the falling edge that follows the rising edge entering a shift state. Every later bit appears one falling edge after the rising edge that shifted it. The bench therefore reads tdo just after each falling edge, before it changes tms or tdi. It also reads tdo once right after a rising edge, to show that tdo has not yet moved. The instruction outputs (test_mode, bus_oe) and bsr_par change on the rising edge that leaves Update-IR or Update-DR. The bench samples them at the falling edge that follows, and it also samples test_mode in Exit1-IR to show that the old opcode still holds there.

// File: rtl/tap_pkg.sv
package tap_pkg;

   localparam int IR_W = 3;

   typedef enum logic [3:0] {
      TS_RESET  = 4'd0,
      TS_IDLE   = 4'd1,
      TS_SEL_DR = 4'd2,
      TS_CAP_DR = 4'd3,
      TS_SH_DR  = 4'd4,
      TS_EX1_DR = 4'd5,
      TS_PAU_DR = 4'd6,
      TS_EX2_DR = 4'd7,
      TS_UPD_DR = 4'd8,
      TS_SEL_IR = 4'd9,
      TS_CAP_IR = 4'd10,
      TS_SH_IR  = 4'd11,
      TS_EX1_IR = 4'd12,
      TS_PAU_IR = 4'd13,
      TS_EX2_IR = 4'd14,
      TS_UPD_IR = 4'd15
   } tap_state_e;

   typedef enum logic [1:0] {
      DR_BYP = 2'd0,
      DR_ID  = 2'd1,
      DR_BSR = 2'd2
   } dr_sel_e;

   localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
   localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
   localparam logic [IR_W-1:0] OP_SAMPZ   = 3'b010;
   localparam logic [IR_W-1:0] OP_PRELOAD = 3'b100;
   localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       por_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e nxt;

   always_comb begin
      unique case (state)
         TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
         TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
         TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SH_DR;
         TS_SH_DR:  nxt = tms ? TS_EX1_DR : TS_SH_DR;
         TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
         TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
         TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SH_DR;
         TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
         TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SH_IR;
         TS_SH_IR:  nxt = tms ? TS_EX1_IR : TS_SH_IR;
         TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
         TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
         TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SH_IR;
         TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
         default:   nxt = TS_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) state <= TS_RESET;
      else        state <= nxt;
   end

   // run length of tms-high edges, saturating at five
   logic [2:0] ones_run;
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)    ones_run <= 3'd0;
      else if (!tms) ones_run <= 3'd0;
      else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
   end

   p_five_ones_reset_r1: assert property (@(posedge tck) disable iff (!por_n)
      (ones_run == 3'd5) |-> (state == TS_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import tap_pkg::*;
(
   input  logic            tck,
   input  logic            por_n,
   input  tap_state_e      state,
   input  logic            tdi,
   output logic [IR_W-1:0] op,
   output logic            so
);

   localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-2){1'b0}}, 2'b01};

   logic [IR_W-1:0] sh;

   if (IR_W < 2) begin : g_bad_irw
      $error("instruction register needs at least two bits");
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) sh <= CAP_PAT;
      else if (state == TS_CAP_IR) sh <= CAP_PAT;
      else if (state == TS_SH_IR)  sh <= {tdi, sh[IR_W-1:1]};
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) op <= OP_IDCODE;
      else if (state == TS_RESET)  op <= OP_IDCODE;
      else if (state == TS_UPD_IR) op <= sh;
   end

   assign so = sh[0];

   p_ir_hold_r3: assert property (@(posedge tck) disable iff (!por_n)
      (state != TS_UPD_IR && state != TS_RESET) |=> $stable(op));

   p_ir_reset_r3: assert property (@(posedge tck) disable iff (!por_n)
      (state == TS_RESET) |=> (op == OP_IDCODE));

endmodule

// File: rtl/tap_shreg.sv
module tap_shreg #(
   parameter int W = 8
) (
   input  logic         tck,
   input  logic         por_n,
   input  logic         cap_en,
   input  logic [W-1:0] cap_val,
   input  logic         sh_en,
   input  logic         tdi,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("shift register width must be positive");
   end

   if (W == 1) begin : g_single
      always_ff @(posedge tck or negedge por_n) begin
         if (!por_n)      q <= '0;
         else if (cap_en) q <= cap_val;
         else if (sh_en)  q <= tdi;
      end
   end else begin : g_multi
      always_ff @(posedge tck or negedge por_n) begin
         if (!por_n)      q <= '0;
         else if (cap_en) q <= cap_val;
         else if (sh_en)  q <= {tdi, q[W-1:1]};
      end
   end

endmodule

// File: rtl/tap_boundary_ctrl.sv
module tap_boundary_ctrl
   import tap_pkg::*;
#(
   parameter int          BSR_LEN  = 12,
   parameter int          OE_CELL  = 5,
   parameter logic [31:0] ID_VALUE = 32'h0C3A_5E2B
) (
   input  logic               tck,
   input  logic               por_n,
   input  logic               tms,
   input  logic               tdi,
   output logic               tdo,
   output logic               tdo_oe,
   input  logic [BSR_LEN-1:0] pin_in,
   input  logic               func_oe,
   output logic [BSR_LEN-1:0] bsr_par,
   output logic               test_mode,
   output logic               bus_oe
);

   localparam int ID_W = 32;

   if (OE_CELL < 0 || OE_CELL >= BSR_LEN) begin : g_bad_oe
      $error("OE_CELL must index a boundary cell");
   end
   if (ID_VALUE[0] != 1'b1) begin : g_bad_id
      $error("identification code must have bit 0 set");
   end

   tap_state_e      state;
   logic [IR_W-1:0] op;
   logic            ir_so;

   tap_fsm u_fsm (
      .tck   (tck),
      .por_n (por_n),
      .tms   (tms),
      .state (state)
   );

   tap_ir u_ir (
      .tck   (tck),
      .por_n (por_n),
      .state (state),
      .tdi   (tdi),
      .op    (op),
      .so    (ir_so)
   );

   // instruction decode; unlisted codes fall to the skip register
   dr_sel_e sel;
   logic    ext, samz, upd_ok;

   always_comb begin
      sel    = DR_BYP;
      ext    = 1'b0;
      samz   = 1'b0;
      upd_ok = 1'b0;
      case (op)
         OP_EXTEST:  begin sel = DR_BSR; ext = 1'b1; upd_ok = 1'b1; end
         OP_IDCODE:  sel = DR_ID;
         OP_SAMPZ:   begin sel = DR_BSR; samz = 1'b1; end
         OP_PRELOAD: begin sel = DR_BSR; upd_ok = 1'b1; end
         default:    sel = DR_BYP;
      endcase
   end

   logic cap_dr, sh_dr, upd_dr;
   assign cap_dr = (state == TS_CAP_DR);
   assign sh_dr  = (state == TS_SH_DR);
   assign upd_dr = (state == TS_UPD_DR);

   logic [ID_W-1:0]    id_q;
   logic [0:0]         byp_q;
   logic [BSR_LEN-1:0] bsr_q;

   tap_shreg #(.W(ID_W)) u_id (
      .tck     (tck),
      .por_n   (por_n),
      .cap_en  (cap_dr && sel == DR_ID),
      .cap_val (ID_VALUE),
      .sh_en   (sh_dr && sel == DR_ID),
      .tdi     (tdi),
      .q       (id_q)
   );

   tap_shreg #(.W(1)) u_byp (
      .tck     (tck),
      .por_n   (por_n),
      .cap_en  (cap_dr && sel == DR_BYP),
      .cap_val (1'b0),
      .sh_en   (sh_dr && sel == DR_BYP),
      .tdi     (tdi),
      .q       (byp_q)
   );

   tap_shreg #(.W(BSR_LEN)) u_bsr (
      .tck     (tck),
      .por_n   (por_n),
      .cap_en  (cap_dr && sel == DR_BSR),
      .cap_val (pin_in),
      .sh_en   (sh_dr && sel == DR_BSR),
      .tdi     (tdi),
      .q       (bsr_q)
   );

   // parallel preload cells
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                bsr_par <= '0;
      else if (state == TS_RESET) bsr_par <= '0;
      else if (upd_dr && upd_ok) bsr_par <= bsr_q;
   end

   logic dr_so;
   always_comb begin
      case (sel)
         DR_ID:   dr_so = id_q[0];
         DR_BSR:  dr_so = bsr_q[0];
         default: dr_so = byp_q[0];
      endcase
   end

   // serial output retimed to the falling edge
   always_ff @(negedge tck or negedge por_n) begin
      if (!por_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo_oe <= (state == TS_SH_DR) || (state == TS_SH_IR);
         if (state == TS_SH_IR)      tdo <= ir_so;
         else if (state == TS_SH_DR) tdo <= dr_so;
      end
   end

   assign test_mode = ext;
   assign bus_oe    = ext ? bsr_par[OE_CELL] : (samz ? 1'b0 : func_oe);

   p_tdo_oe_shift_r2: assert property (@(posedge tck) disable iff (!por_n)
      tdo_oe |-> (state == TS_SH_DR || state == TS_SH_IR));

   p_samplez_hiz_r9: assert property (@(posedge tck) disable iff (!por_n)
      (op == OP_SAMPZ) |-> !bus_oe);

   p_par_hold_r8: assert property (@(posedge tck) disable iff (!por_n)
      (state != TS_UPD_DR && state != TS_RESET) |=> $stable(bsr_par));

   p_reserved_noupd_r12: assert property (@(posedge tck) disable iff (!por_n)
      (upd_dr && op != OP_EXTEST && op != OP_PRELOAD) |=> $stable(bsr_par));

   p_reset_clear_r11: assert property (@(posedge tck) disable iff (!por_n)
      (state == TS_RESET) |=> (bsr_par == '0));

endmodule

// File: tb/tb_tap_boundary_ctrl.sv
module tb_tap_boundary_ctrl;

   localparam int          L   = 12;
   localparam int          OEC = 5;
   localparam logic [31:0] IDV = 32'h0C3A_5E2B;
   localparam logic [L-1:0] PIN = 12'hB36;
   localparam logic [63:0] PAT  = 64'h0000_A5C3_96F0_3C5A;
   localparam logic [63:0] PAT2 = 64'h0000_5A3C_69F0_C3A5;

   // op[4:2], register kind[1:0]: 0 boundary, 1 id, 2 bypass
   localparam logic [4:0] VEC [8] = '{
      {3'b000, 2'd0}, {3'b001, 2'd1}, {3'b010, 2'd0}, {3'b011, 2'd2},
      {3'b100, 2'd0}, {3'b101, 2'd2}, {3'b110, 2'd2}, {3'b111, 2'd2}
   };

   logic tck = 1'b0;
   logic por_n = 1'b0;
   logic tms = 1'b1;
   logic tdi = 1'b0;
   logic tdo, tdo_oe, func_oe, test_mode, bus_oe;
   logic [L-1:0] pin_in, bsr_par;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 tck = ~tck;

   tap_boundary_ctrl #(.BSR_LEN(L), .OE_CELL(OEC), .ID_VALUE(IDV)) dut (
      .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
      .pin_in(pin_in), .func_oe(func_oe), .bsr_par(bsr_par),
      .test_mode(test_mode), .bus_oe(bus_oe)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one rising edge: sample after the falling edge, then set inputs
   task automatic step(input logic t_ms, input logic t_di, output logic o_do, output logic o_oe);
      @(negedge tck); #2;
      o_do = tdo; o_oe = tdo_oe;
      tms = t_ms; tdi = t_di;
   endtask

   task automatic observe();
      @(negedge tck); #2;
   endtask

   task automatic shift_ir(input logic [2:0] op, output logic [2:0] cap, output logic pre_mode);
      logic d, o;
      step(1, 0, d, o); step(1, 0, d, o); step(0, 0, d, o); step(0, 0, d, o);
      for (int i = 0; i < 3; i++) begin
         step(i == 2, op[i], d, o);
         cap[i] = d;
      end
      step(1, 0, d, o);
      pre_mode = test_mode;
      step(0, 0, d, o);
   endtask

   task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout,
                           output logic oe_all);
      logic d, o;
      dout = '0; oe_all = 1'b1;
      step(1, 0, d, o); step(0, 0, d, o); step(0, 0, d, o);
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, din[i], d, o);
         dout[i] = d;
         if (!o) oe_all = 1'b0;
      end
      step(1, 0, d, o); step(0, 0, d, o);
   endtask

   function automatic logic [63:0] exp_dr(input int kind, input int n, input logic [63:0] din);
      logic [63:0] r = '0;
      for (int i = 0; i < n; i++) begin
         if (kind == 2)      r[i] = (i == 0) ? 1'b0 : din[i-1];
         else if (kind == 1) r[i] = (i < 32) ? IDV[i] : din[i-32];
         else                r[i] = (i < L) ? PIN[i] : din[i-L];
      end
      return r;
   endfunction

   initial begin
      repeat (100000) @(posedge tck);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R1 watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [2:0] cap;
      logic pre, oe_all, d, o;
      logic [63:0] dout;
      logic [L-1:0] exp_par;
      int prev_op;
      pin_in = PIN;
      func_oe = 1'b1;
      repeat (3) @(negedge tck);
      #2;
      // reset state
      chk("R2 tdo_oe after power-up", 64'(tdo_oe), 64'd0);
      chk("R11 bsr_par after power-up", 64'(bsr_par), 64'd0);
      chk("R10 test_mode after power-up", 64'(test_mode), 64'd0);
      chk("R9 bus_oe follows func_oe at power-up", 64'(bus_oe), 64'd1);
      por_n = 1'b1;
      step(0, 0, d, o);
      // power-up instruction is IDCODE
      shift_dr(40, PAT, dout, oe_all);
      chk("R3 R7 R5 id after power-up", dout & 64'hFF_FFFF_FFFF, exp_dr(1, 40, PAT));
      chk("R2 tdo_oe through shift", 64'(oe_all), 64'd1);
      observe();
      chk("R2 tdo_oe in idle", 64'(tdo_oe), 64'd0);

      // table walk over all eight codes
      exp_par = '0;
      prev_op = 1;
      for (int k = 0; k < 8; k++) begin
         logic [2:0] op;
         int kind;
         logic exp_oe;
         op = VEC[k][4:2];
         kind = int'(VEC[k][1:0]);
         shift_ir(op, cap, pre);
         chk("R4 capture-IR pattern", 64'(cap), 64'd1);
         chk("R3 old opcode holds until update", 64'(pre), 64'(prev_op == 0));
         observe();
         chk("R10 test_mode per opcode", 64'(test_mode), 64'(op == 3'b000));
         shift_dr(48, PAT, dout, oe_all);
         observe();
         if (kind == 2)      chk("R6 R12 bypass path", dout & 64'hFFFF_FFFF_FFFF, exp_dr(2, 48, PAT));
         else if (kind == 1) chk("R7 R5 id path", dout & 64'hFFFF_FFFF_FFFF, exp_dr(1, 48, PAT));
         else                chk("R8 R5 boundary path", dout & 64'hFFFF_FFFF_FFFF, exp_dr(0, 48, PAT));
         if (op == 3'b000 || op == 3'b100) exp_par = PAT[47:36];
         chk("R8 R12 preload cells after update", 64'(bsr_par), 64'(exp_par));
         if (op == 3'b000)      exp_oe = exp_par[OEC];
         else if (op == 3'b010) exp_oe = 1'b0;
         else                   exp_oe = func_oe;
         chk("R9 R12 bus_oe per opcode", 64'(bus_oe), 64'(exp_oe));
         prev_op = int'(op);
      end

      // preload an enabling value, then EXTEST drives the bus
      shift_ir(3'b100, cap, pre);
      shift_dr(48, PAT2, dout, oe_all);
      observe();
      chk("R8 preload PAT2", 64'(bsr_par), 64'(PAT2[47:36]));
      func_oe = 1'b0;
      shift_ir(3'b000, cap, pre);
      observe();
      chk("R9 EXTEST enable cell high", 64'(bus_oe), 64'd1);

      // SAMPLE Z forces high impedance through a DR scan
      func_oe = 1'b1;
      shift_ir(3'b010, cap, pre);
      observe();
      chk("R9 SAMPLE Z bus off", 64'(bus_oe), 64'd0);
      shift_dr(20, PAT, dout, oe_all);
      observe();
      chk("R9 SAMPLE Z holds after DR scan", 64'(bus_oe), 64'd0);
      chk("R8 SAMPLE Z update leaves cells", 64'(bsr_par), 64'(PAT2[47:36]));
      shift_ir(3'b111, cap, pre);
      observe();
      chk("R9 bus follows func_oe after update-IR", 64'(bus_oe), 64'd1);

      // tdo moves only on the falling edge (bypass selected)
      step(1, 0, d, o); step(0, 0, d, o); step(0, 0, d, o);
      step(0, 1, d, o);
      chk("R6 bypass captured zero", 64'(d), 64'd0);
      @(posedge tck); #2;
      chk("R2 tdo unchanged after rising edge", 64'(tdo), 64'd0);
      step(1, 0, d, o);
      chk("R6 one-bit delay", 64'(d), 64'd1);
      step(1, 0, d, o); step(0, 0, d, o);

      // reset from mid-shift while EXTEST holds nonzero cells
      shift_ir(3'b000, cap, pre);
      step(1, 0, d, o); step(0, 0, d, o); step(0, 0, d, o); step(0, 1, d, o);
      for (int i = 0; i < 5; i++) step(1, 0, d, o);
      step(0, 0, d, o);
      observe();
      chk("R1 R11 cells cleared by reset", 64'(bsr_par), 64'd0);
      chk("R1 R10 test_mode off after reset", 64'(test_mode), 64'd0);
      shift_dr(32, PAT, dout, oe_all);
      chk("R1 R3 IDCODE restored", dout & 64'hFFFF_FFFF, 64'(IDV));

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule